// File: doc/BRIEF.md
# Truth-Table ALU with Barrel Shifter

This block is a purely combinational 32-bit arithmetic and logic unit. It contains three units: an adder/subtractor, a bitwise logic unit and a barrel shifter. A 2-bit unit select picks which unit drives the result, or turns the whole ALU off. The adder reports carry-out, signed overflow and zero.

The logic unit has no list of opcodes. It takes a 4-bit truth-table code. For every bit position, the operand pair (A[n], B[n]) forms a 2-bit index, and that index selects one code bit as the result bit. One code therefore gives any of the sixteen two-input Boolean functions.

The shifter moves A by the amount held in the low bits of B. It does logical shifts, arithmetic shifts and rotates, in either direction. A surrounding datapath places registers on both sides of the block. The block holds no state of its own.

Top module: `truth_alu`

## Requirements
- R1: `unit_sel` 2'b00 routes the adder/subtractor to `result`, 2'b01 routes the logic unit and 2'b10 routes the shifter.
- R2: With `unit_sel` = 2'b11, `result` is all zeros and `carry_out`, `overflow` and `zero` are all 0, whatever the other inputs are.
- R3: With `sub_en` = 0, `{carry_out, result}` equals the 33-bit sum A + B + `carry_in`.
- R4: With `sub_en` = 1, `result` equals A − B modulo 2^32 and `carry_in` has no effect. `carry_out` is the carry of A + ~B + 1, which is 1 exactly when A ≥ B unsigned.
- R5: In the adder unit, `overflow` is 1 exactly when the two's-complement result has the wrong sign: both effective operands (B, or ~B when subtracting) share a sign bit, and the result sign differs from it.
- R6: While the ALU is enabled, `zero` is 1 exactly when `result` is all zeros, for every unit.
- R7: Logic result bit n equals `logic_code[{A[n],B[n]}]`. Index 0 is the pair (0,0), index 1 is (0,1), index 2 is (1,0) and index 3 is (1,1).
- R8: The code values on the port are 4'h8 for AND, 4'hC to pass A, 4'hA to pass B, 4'h6 for XOR, 4'hE for OR, 4'h0 for constant zero and 4'hF for all ones.
- R9: `shift_kind` 2'b00 gives `result` = A unchanged, in both directions.
- R10: `shift_kind` 2'b01 is a logical shift that fills with zeros. `shift_right` 0 shifts left and 1 shifts right.
- R11: `shift_kind` 2'b10 to the right fills with A[31]. To the left it gives the same result as a logical left shift.
- R12: `shift_kind` 2'b11 rotates A by the amount, left or right, and no bit is lost.
- R13: The shift amount is B[4:0] (0 to 31). B[31:5] has no effect on the shifter.
- R14: When the logic unit or the shifter is selected, `carry_out` and `overflow` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | 32 | Operand A; also the value that is shifted |
| b | input | 32 | Operand B; low 5 bits give the shift amount |
| unit_sel | input | 2 | 00 add/sub, 01 logic, 10 shift, 11 off |
| sub_en | input | 1 | 0 add, 1 subtract |
| carry_in | input | 1 | Carry into the adder (addition only) |
| logic_code | input | 4 | Truth-table code for the logic unit |
| shift_kind | input | 2 | 00 none, 01 logical, 10 arithmetic, 11 rotate |
| shift_right | input | 1 | 0 left, 1 right |
| result | output | 32 | Selected unit output |
| carry_out | output | 1 | Adder carry-out |
| overflow | output | 1 | Adder signed overflow |
| zero | output | 1 | Result is zero while the ALU is enabled |

## Verification
The assertions are immediate checks on settled combinational values. They assume that all inputs hold known 0/1 values and that the inputs change only between evaluations. The bench keeps to this by setting every input together on the falling clock edge. It compares the outputs one nanosecond later, so no assertion sees a half-updated input set. Every input is driven from time zero, so no check evaluates an unknown operand.

// File: rtl/truth_alu_pkg.sv
package truth_alu_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned SHAMT_W = $clog2(DATA_W);

  typedef enum logic [1:0] {
    UNIT_ARITH = 2'b00,
    UNIT_LOGIC = 2'b01,
    UNIT_SHIFT = 2'b10,
    UNIT_OFF   = 2'b11
  } unit_sel_e;

  typedef enum logic [1:0] {
    SHK_NONE  = 2'b00,
    SHK_LOGIC = 2'b01,
    SHK_ARITH = 2'b10,
    SHK_ROT   = 2'b11
  } shift_kind_e;

  typedef struct packed {
    logic carry;
    logic ovf;
  } arith_flags_t;
endpackage

// File: rtl/truth_alu_addsub.sv
module truth_alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         subtract,
  input  logic         cin,
  output logic [W-1:0] sum,
  output truth_alu_pkg::arith_flags_t flags
);
  logic [W-1:0] b_eff;
  logic         c_eff;
  logic [W:0]   wide;

  always_comb begin
    b_eff = subtract ? ~op_b : op_b;
    c_eff = subtract ? 1'b1 : cin;
    wide  = {1'b0, op_a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
    sum   = wide[W-1:0];
    flags.carry = wide[W];
    flags.ovf   = (op_a[W-1] == b_eff[W-1]) && (wide[W-1] != op_a[W-1]);
  end
endmodule

// File: rtl/truth_alu_logic.sv
module truth_alu_logic #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [3:0]   code,
  output logic [W-1:0] out
);
  for (genvar n = 0; n < W; n++) begin : g_slice
    logic [1:0] idx;
    assign idx    = {op_a[n], op_b[n]};
    assign out[n] = code[idx];
  end
endmodule

// File: rtl/truth_alu_shift.sv
module truth_alu_shift #(
  parameter int unsigned W  = 32,
  parameter int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]  op_a,
  input  logic [SW-1:0] amount,
  input  truth_alu_pkg::shift_kind_e kind,
  input  logic          to_right,
  output logic [W-1:0]  out
);
  import truth_alu_pkg::*;

  logic [W-1:0] flipped_in;
  logic [W-1:0] core_in;
  logic [W-1:0] core_out;
  logic [W-1:0] flipped_out;
  logic         fill_bit;
  logic         wrap;
  logic [W-1:0] stage [0:SW];

  for (genvar i = 0; i < W; i++) begin : g_flip
    assign flipped_in[i]  = op_a[W-1-i];
    assign flipped_out[i] = core_out[W-1-i];
  end

  assign core_in  = to_right ? op_a : flipped_in;
  assign fill_bit = (kind == SHK_ARITH) && to_right && op_a[W-1];
  assign wrap     = (kind == SHK_ROT);
  assign stage[0] = core_in;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int unsigned S = 1 << k;
    logic [W-1:0] rotated;
    logic [W-1:0] filled;
    assign rotated = {stage[k][S-1:0], stage[k][W-1:S]};
    assign filled  = {{S{fill_bit}}, stage[k][W-1:S]};
    assign stage[k+1] = !amount[k] ? stage[k] : (wrap ? rotated : filled);
  end

  assign core_out = stage[SW];

  always_comb begin
    if (kind == SHK_NONE) out = op_a;
    else if (to_right)    out = core_out;
    else                  out = flipped_out;
  end
endmodule

// File: rtl/truth_alu.sv
module truth_alu (
  input  logic [31:0] a,
  input  logic [31:0] b,
  input  logic [1:0]  unit_sel,
  input  logic        sub_en,
  input  logic        carry_in,
  input  logic [3:0]  logic_code,
  input  logic [1:0]  shift_kind,
  input  logic        shift_right,
  output logic [31:0] result,
  output logic        carry_out,
  output logic        overflow,
  output logic        zero
);
  import truth_alu_pkg::*;

  localparam int unsigned W  = DATA_W;
  localparam int unsigned SW = SHAMT_W;

  logic [W-1:0]  arith_res;
  logic [W-1:0]  logic_res;
  logic [W-1:0]  shift_res;
  arith_flags_t  arith_flg;
  unit_sel_e     sel;
  shift_kind_e   kind;

  assign sel  = unit_sel_e'(unit_sel);
  assign kind = shift_kind_e'(shift_kind);

  truth_alu_addsub #(.W(W)) u_addsub (
    .op_a(a), .op_b(b), .subtract(sub_en), .cin(carry_in),
    .sum(arith_res), .flags(arith_flg)
  );

  truth_alu_logic #(.W(W)) u_logic (
    .op_a(a), .op_b(b), .code(logic_code), .out(logic_res)
  );

  truth_alu_shift #(.W(W), .SW(SW)) u_shift (
    .op_a(a), .amount(b[SW-1:0]), .kind(kind), .to_right(shift_right),
    .out(shift_res)
  );

  always_comb begin
    result    = '0;
    carry_out = 1'b0;
    overflow  = 1'b0;
    unique case (sel)
      UNIT_ARITH: begin
        result    = arith_res;
        carry_out = arith_flg.carry;
        overflow  = arith_flg.ovf;
      end
      UNIT_LOGIC: result = logic_res;
      UNIT_SHIFT: result = shift_res;
      default:    result = '0;
    endcase
    zero = (sel != UNIT_OFF) && (result == '0);
  end
endmodule

// File: rtl/truth_alu_checker.sv
module truth_alu_checker (
  input logic [31:0] a,
  input logic [31:0] b,
  input logic [1:0]  unit_sel,
  input logic        sub_en,
  input logic        carry_in,
  input logic [3:0]  logic_code,
  input logic [1:0]  shift_kind,
  input logic        shift_right,
  input logic [31:0] result,
  input logic        carry_out,
  input logic        overflow,
  input logic        zero
);
  always_comb begin
    if (unit_sel == 2'b11)
      assert_off_quiet_R2: assert (result == 32'd0 && !carry_out && !overflow && !zero);
    if (unit_sel == 2'b00 && !sub_en)
      assert_add_sum_R3: assert ({carry_out, result} == ({1'b0, a} + {1'b0, b} + {32'd0, carry_in}));
    if (unit_sel == 2'b00 && sub_en)
      assert_sub_diff_R4: assert (result == a - b);
    if (unit_sel != 2'b11)
      assert_zero_flag_R6: assert (zero == (result == 32'd0));
    if (unit_sel == 2'b01 && logic_code == 4'h6)
      assert_xor_code_R8: assert (result == (a ^ b));
    if (unit_sel == 2'b10 && shift_kind == 2'b00)
      assert_pass_through_R9: assert (result == a);
    if (unit_sel == 2'b01 || unit_sel == 2'b10)
      assert_no_overflow_R14: assert (!carry_out && !overflow);
  end
endmodule

bind truth_alu truth_alu_checker u_truth_alu_checker (
  .a(a), .b(b), .unit_sel(unit_sel), .sub_en(sub_en), .carry_in(carry_in),
  .logic_code(logic_code), .shift_kind(shift_kind), .shift_right(shift_right),
  .result(result), .carry_out(carry_out), .overflow(overflow), .zero(zero)
);

// File: tb/truth_alu_test.sv
module truth_alu_test;
  logic        clk;
  logic        rst_n;
  logic [31:0] a, b;
  logic [1:0]  unit_sel;
  logic        sub_en, carry_in, shift_right;
  logic [3:0]  logic_code;
  logic [1:0]  shift_kind;
  logic [31:0] result;
  logic        carry_out, overflow, zero;
  int          checks, errors;
  bit          done;

  truth_alu uut (
    .a(a), .b(b), .unit_sel(unit_sel), .sub_en(sub_en), .carry_in(carry_in),
    .logic_code(logic_code), .shift_kind(shift_kind), .shift_right(shift_right),
    .result(result), .carry_out(carry_out), .overflow(overflow), .zero(zero)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [32:0] got, input logic [32:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", req, got, exp);
    end
  endtask

  task automatic put(input logic [1:0] us, input logic [31:0] va, input logic [31:0] vb,
                     input logic se, input logic ci, input logic [3:0] lc,
                     input logic [1:0] sk, input logic sr);
    @(negedge clk);
    unit_sel = us; a = va; b = vb; sub_en = se; carry_in = ci;
    logic_code = lc; shift_kind = sk; shift_right = sr;
    #1;
  endtask

  function automatic logic [31:0] rotr(input logic [31:0] v, input int n);
    return (n == 0) ? v : ((v >> n) | (v << (32 - n)));
  endfunction

  task automatic t_reset_off();
    chk("R2 reset result", {1'b0, result}, 33'd0);
    chk("R2 reset flags", {30'd0, carry_out, overflow, zero}, 33'd0);
    put(2'b11, 32'hFFFF_FFFF, 32'h1, 1'b0, 1'b1, 4'hF, 2'b01, 1'b0);
    chk("R2 off result", {1'b0, result}, 33'd0);
    chk("R2 off flags", {30'd0, carry_out, overflow, zero}, 33'd0);
  endtask

  task automatic t_add();
    logic [32:0] e;
    put(2'b00, 32'h1234_5678, 32'h1111_1111, 1'b0, 1'b0, 4'h0, 2'b00, 1'b0);
    chk("R1 R3 add", {carry_out, result}, 33'h0_2345_6789);
    put(2'b00, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b1, 4'h0, 2'b00, 1'b0);
    chk("R3 carry wrap", {carry_out, result}, 33'h1_0000_0000);
    chk("R6 zero on add", {32'd0, zero}, 33'd1);
    put(2'b00, 32'h7FFF_FFFF, 32'h1, 1'b0, 1'b0, 4'h0, 2'b00, 1'b0);
    chk("R5 pos overflow", {32'd0, overflow}, 33'd1);
    put(2'b00, 32'h8000_0000, 32'h8000_0000, 1'b0, 1'b0, 4'h0, 2'b00, 1'b0);
    chk("R5 neg overflow", {32'd0, overflow}, 33'd1);
    chk("R6 zero after wrap", {32'd0, zero}, 33'd1);
    put(2'b00, 32'hDEAD_0000, 32'h0000_BEEF, 1'b0, 1'b1, 4'h0, 2'b00, 1'b0);
    e = {1'b0, 32'hDEAD_0000} + {1'b0, 32'h0000_BEEF} + 33'd1;
    chk("R3 add cin", {carry_out, result}, e);
    chk("R5 no overflow", {32'd0, overflow}, 33'd0);
  endtask

  task automatic t_sub();
    put(2'b00, 32'd10, 32'd3, 1'b1, 1'b0, 4'h0, 2'b00, 1'b0);
    chk("R4 sub", {carry_out, result}, {1'b1, 32'd7});
    put(2'b00, 32'd10, 32'd3, 1'b1, 1'b1, 4'h0, 2'b00, 1'b0);
    chk("R4 cin ignored", {carry_out, result}, {1'b1, 32'd7});
    put(2'b00, 32'd3, 32'd10, 1'b1, 1'b0, 4'h0, 2'b00, 1'b0);
    chk("R4 borrow", {carry_out, result}, {1'b0, 32'hFFFF_FFF9});
    put(2'b00, 32'h8000_0000, 32'h1, 1'b1, 1'b0, 4'h0, 2'b00, 1'b0);
    chk("R5 sub overflow", {32'd0, overflow}, 33'd1);
    put(2'b00, 32'h55, 32'h55, 1'b1, 1'b0, 4'h0, 2'b00, 1'b0);
    chk("R6 sub equal zero", {30'd0, carry_out, overflow, zero}, 33'b101);
  endtask

  task automatic t_logic();
    logic [31:0] va, vb, ex;
    va = 32'hF0F0_CC33; vb = 32'hFF00_AA55;
    for (int c = 0; c < 16; c++) begin
      ex = ({32{c[0]}} & ~va & ~vb) | ({32{c[1]}} & ~va & vb) |
           ({32{c[2]}} & va & ~vb) | ({32{c[3]}} & va & vb);
      put(2'b01, va, vb, 1'b0, 1'b1, c[3:0], 2'b00, 1'b0);
      chk("R7 code sweep", {1'b0, result}, {1'b0, ex});
      chk("R14 logic flags", {31'd0, carry_out, overflow}, 33'd0);
    end
    put(2'b01, va, vb, 1'b0, 1'b0, 4'h8, 2'b00, 1'b0);
    chk("R8 AND", {1'b0, result}, {1'b0, va & vb});
    put(2'b01, va, vb, 1'b0, 1'b0, 4'hC, 2'b00, 1'b0);
    chk("R8 pass A", {1'b0, result}, {1'b0, va});
    put(2'b01, va, vb, 1'b0, 1'b0, 4'hA, 2'b00, 1'b0);
    chk("R8 pass B", {1'b0, result}, {1'b0, vb});
    put(2'b01, va, vb, 1'b0, 1'b0, 4'h6, 2'b00, 1'b0);
    chk("R8 XOR", {1'b0, result}, {1'b0, va ^ vb});
    put(2'b01, va, vb, 1'b0, 1'b0, 4'hE, 2'b00, 1'b0);
    chk("R8 OR", {1'b0, result}, {1'b0, va | vb});
    put(2'b01, va, vb, 1'b0, 1'b0, 4'h0, 2'b00, 1'b0);
    chk("R6 R8 const zero", {zero, result}, 33'h1_0000_0000);
  endtask

  task automatic t_shift();
    logic [31:0] va;
    va = 32'h8765_4321;
    put(2'b10, va, 32'd7, 1'b0, 1'b0, 4'h0, 2'b00, 1'b1);
    chk("R9 no shift", {1'b0, result}, {1'b0, va});
    for (int n = 0; n < 32; n += 5) begin
      put(2'b10, va, n, 1'b0, 1'b0, 4'h0, 2'b01, 1'b0);
      chk("R10 lsl", {1'b0, result}, {1'b0, va << n});
      put(2'b10, va, n, 1'b0, 1'b0, 4'h0, 2'b01, 1'b1);
      chk("R10 lsr", {1'b0, result}, {1'b0, va >> n});
      put(2'b10, va, n, 1'b0, 1'b0, 4'h0, 2'b10, 1'b1);
      chk("R11 asr", {1'b0, result}, {1'b0, 32'($signed(va) >>> n)});
      put(2'b10, va, n, 1'b0, 1'b0, 4'h0, 2'b10, 1'b0);
      chk("R11 asl", {1'b0, result}, {1'b0, va << n});
      put(2'b10, va, n, 1'b0, 1'b0, 4'h0, 2'b11, 1'b1);
      chk("R12 ror", {1'b0, result}, {1'b0, rotr(va, n)});
      put(2'b10, va, n, 1'b0, 1'b0, 4'h0, 2'b11, 1'b0);
      chk("R12 rol", {1'b0, result}, {1'b0, rotr(va, (32 - n) % 32)});
      chk("R14 shift flags", {31'd0, carry_out, overflow}, 33'd0);
    end
    put(2'b10, 32'h4000_0000, 32'd31, 1'b0, 1'b0, 4'h0, 2'b10, 1'b1);
    chk("R11 asr positive", {1'b0, result}, 33'd0);
    put(2'b10, va, 32'hFFFF_FFE3, 1'b0, 1'b0, 4'h0, 2'b01, 1'b1);
    chk("R13 upper b ignored", {1'b0, result}, {1'b0, va >> 3});
    put(2'b10, va, 32'h0000_0020, 1'b0, 1'b0, 4'h0, 2'b11, 1'b0);
    chk("R13 amount 32 is 0", {1'b0, result}, {1'b0, va});
    put(2'b10, 32'h1, 32'd1, 1'b0, 1'b0, 4'h0, 2'b01, 1'b1);
    chk("R6 shift to zero", {32'd0, zero}, 33'd1);
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0;
    a = '0; b = '0; unit_sel = 2'b11; sub_en = 1'b0; carry_in = 1'b0;
    logic_code = 4'h0; shift_kind = 2'b00; shift_right = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_off();
    t_add();
    t_sub();
    t_logic();
    t_shift();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule